// File: doc/BRIEF.md
# Brake Input Glitch Filter

This block conditions two asynchronous fault inputs before they can stop a power stage. Each input is brought into the system clock domain, optionally complemented, and then passed through a counting filter. The filter accepts a new level only after enough consecutive samples agree with it. The filtered level feeds a falling-edge detector. That detector emits a one-cycle brake pulse each time the conditioned signal goes from high to low.

Software sets up each channel through one 32-bit control word, written with a plain write strobe and always readable. Each channel has four controls: an enable for the filter, a power-of-two sampling-rate divider, a stability count, and an input inversion. When the filter is off, the synchronised and optionally inverted input drives the detector directly. All logic runs on the single system clock, and the divided sampling rate comes from one-cycle enable strobes.

Top module: `brk_glitch_filter`

## Requirements
- R1: The control word resets to 0 and updates on the clock edge where `wr_en_i` is high. Channel c occupies bits [8c+7:8c]. Within that byte, bit 0 is the filter enable, bits [3:1] are the sampling-rate code n, bits [6:4] are the stability count N, and bit 7 is the inversion.
- R2: Bits [31:16] always read 0, and writes to them have no effect. This includes the per-channel source selects at bits 16 and 24, because their only legal value is 0.
- R3: Each input passes through two synchroniser flops that reset to 1. With the filter disabled, a pin change applied before clock edge k shows on `level_o` after edge k+2.
- R4: With the inversion bit set, the complement of the synchronised pin is filtered. With the bit clear, the pin passes unchanged.
- R5: Sampling code n makes the filter sample once every 2^n clocks. The samples fall on the edges where the low n bits of a free-running 7-bit counter are 0. That counter is 0 at the first edge after reset and wraps at 128.
- R6: With the filter enabled and count N, `level_o` takes a new value at the (N+1)th consecutive sample that differs from it. The stability counter is cleared at the same sample.
- R7: A sample equal to the current filtered level clears the stability counter. A pulse that is shorter than the qualifying run therefore never reaches `level_o`.
- R8: `brake_o` is high for exactly one clock, in the cycle after `level_o` changes from 1 to 0. A rising level produces no pulse.
- R9: After reset, `level_o` is all ones and `brake_o` is all zeros.
- R10: With the filter enable clear, `level_o` follows the conditioned input every clock, whatever the sampling code and count are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control word read-back |
| pin_i | input | 2 | Asynchronous brake inputs, one per channel |
| level_o | output | 2 | Filtered conditioned level per channel |
| brake_o | output | 2 | One-cycle falling-edge brake pulse per channel |

## Verification
A write appears on `rd_data_o` one edge after the strobe. In bypass, a pin change reaches `level_o` three edges later. When filtering, the filtered level moves at the (N+1)th qualifying strobe edge after the input reaches the synchroniser output. `brake_o` follows the falling level in that same sampled cycle. The bench model advances these delays register by register at each rising edge, using the same free-running strobe phase. Every output is compared at the falling edge between, so each expected value is due exactly when the design's registers have settled.

// File: rtl/brk_filter_pkg.sv
package brk_filter_pkg;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned CNT_W = 3;
  localparam int unsigned NUM_SEL = 1 << SEL_W;
  localparam int unsigned PRE_W = NUM_SEL - 1;

  typedef struct packed {
    logic             inv;
    logic [CNT_W-1:0] thresh;
    logic [SEL_W-1:0] rate;
    logic             en;
  } chan_cfg_t;
endpackage

// File: rtl/brk_cfg_reg.sv
module brk_cfg_reg
  import brk_filter_pkg::*;
#(
  parameter int unsigned NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [NUM_CH*8-1:0] wr_data_i,
  output logic [NUM_CH*8-1:0] cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_o <= '0;
    else if (wr_en_i) cfg_o <= wr_data_i;
  end
endmodule

// File: rtl/brk_prescaler.sv
module brk_prescaler
  import brk_filter_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [NUM_SEL-1:0] strb_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_strb
    if (k == 0) begin : g_full
      assign strb_o[k] = 1'b1;
    end else begin : g_div
      assign strb_o[k] = ~|cnt_q[k-1:0];
    end
  end
endmodule

// File: rtl/brk_channel.sv
module brk_channel
  import brk_filter_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               pin_i,
  input  chan_cfg_t          cfg_i,
  input  logic [NUM_SEL-1:0] strb_i,
  output logic               level_o,
  output logic               brake_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   level_q, prev_q, cond, strb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign cond = sync_q[SYNC_STAGES-1] ^ cfg_i.inv;
  assign strb = strb_i[cfg_i.rate];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
      prev_q  <= 1'b1;
    end else begin
      prev_q <= level_q;
      if (!cfg_i.en) begin
        level_q <= cond;
        cnt_q   <= '0;
      end else if (strb) begin
        if (cond == level_q) begin
          cnt_q <= '0;
        end else if (cnt_q >= cfg_i.thresh) begin
          level_q <= cond;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign level_o = level_q;
  assign brake_o = prev_q & ~level_q;

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brake_o |=> !brake_o);
  a_r8_pulse_on_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brake_o |-> !level_o);
  a_r10_bypass_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |=> level_o == $past(cond));
  a_r5_hold_between_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !strb) |=> $stable(level_o));
endmodule

// File: rtl/brk_glitch_filter.sv
module brk_glitch_filter
  import brk_filter_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [NUM_CH-1:0] pin_i,
  output logic [NUM_CH-1:0] level_o,
  output logic [NUM_CH-1:0] brake_o
);
  localparam int unsigned CFG_W = NUM_CH * 8;

  logic [CFG_W-1:0]   cfg_q;
  logic [NUM_SEL-1:0] strb;
  logic               unused_hi;

  assign unused_hi = ^wr_data_i[31:CFG_W];

  brk_cfg_reg #(.NUM_CH(NUM_CH)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i[CFG_W-1:0]),
    .cfg_o     (cfg_q)
  );

  assign rd_data_o = {{(32-CFG_W){1'b0}}, cfg_q};

  brk_prescaler u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .strb_o (strb)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    brk_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .pin_i   (pin_i[c]),
      .cfg_i   (chan_cfg_t'(cfg_q[c*8 +: 8])),
      .strb_i  (strb),
      .level_o (level_o[c]),
      .brake_o (brake_o[c])
    );
  end

  a_r2_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[31:16] == 16'h0);
endmodule

// File: tb/brk_glitch_filter_test.sv
module brk_glitch_filter_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic [1:0]  pin_i = 2'b11;
  logic [1:0]  level_o, brake_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_reg, m_pc;
  int m_s1[2], m_s2[2], m_lvl[2], m_prev[2], m_cnt[2];

  always #2.5 clk_i = ~clk_i;

  brk_glitch_filter uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .pin_i(pin_i), .level_o(level_o), .brake_o(brake_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_reg = 0; m_pc = 0;
      for (int c = 0; c < 2; c++) begin
        m_s1[c] = 1; m_s2[c] = 1; m_lvl[c] = 1; m_prev[c] = 1; m_cnt[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int b, en, rate, th, cond;
        b = (m_reg >> (8*c)) & 255;
        en = b & 1; rate = (b >> 1) & 7; th = (b >> 4) & 7;
        cond = m_s2[c] ^ ((b >> 7) & 1);
        m_prev[c] = m_lvl[c];
        if (en == 0) begin
          m_lvl[c] = cond; m_cnt[c] = 0;
        end else if ((m_pc % (1 << rate)) == 0) begin
          if (cond == m_lvl[c]) m_cnt[c] = 0;
          else if (m_cnt[c] >= th) begin m_lvl[c] = cond; m_cnt[c] = 0; end
          else m_cnt[c]++;
        end
        m_s2[c] = m_s1[c]; m_s1[c] = int'(pin_i[c]);
      end
      m_pc = (m_pc + 1) % 128;
      if (wr_en_i) m_reg = int'(wr_data_i & 32'h0000_FFFF);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      for (int c = 0; c < 2; c++) begin
        check(level_o[c] == m_lvl[c][0], "R6 level", int'(level_o[c]), m_lvl[c]);
        check(brake_o[c] == (m_prev[c][0] & ~m_lvl[c][0]), "R8 brake",
              int'(brake_o[c]), m_prev[c] & ~m_lvl[c]);
      end
      check(rd_data_o == m_reg, "R1 readback", int'(rd_data_o), m_reg);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en_i = 1'b1; wr_data_i = d; cyc(1); wr_en_i = 1'b0;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    // R9 reset state
    check(level_o == 2'b11, "R9 level after reset", int'(level_o), 3);
    check(brake_o == 2'b00, "R9 brake after reset", int'(brake_o), 0);
    check(rd_data_o == 0, "R1 reset value", int'(rd_data_o), 0);

    // R2 upper bits ignored, source selects included
    wr(32'hFFFF_FFFF);
    check(rd_data_o == 32'h0000_FFFF, "R2 reserved bits", int'(rd_data_o), 32'hFFFF);
    wr(32'h0101_0000);
    check(rd_data_o == 0, "R2 source selects", int'(rd_data_o), 0);

    // R3/R10 bypass with nonzero rate and count: pin drop at 3rd edge
    wr(32'h0000_7E7E);
    pin_i[0] = 1'b0;
    cyc(2);
    check(level_o[0] == 1'b1, "R3 before sync latency", int'(level_o[0]), 1);
    cyc(1);
    check(level_o[0] == 1'b0, "R10 bypass follows", int'(level_o[0]), 0);
    check(brake_o[0] == 1'b1, "R8 pulse on fall", int'(brake_o[0]), 1);
    cyc(1);
    check(brake_o[0] == 1'b0, "R8 single cycle", int'(brake_o[0]), 0);
    pin_i[0] = 1'b1; cyc(4);
    check(brake_o[0] == 1'b0 && level_o[0], "R8 no pulse on rise", int'(brake_o[0]), 0);

    // R4 inversion on channel 1, bypass: high pin gives low level
    wr(32'h0000_8000);
    cyc(4);
    check(level_o[1] == 1'b0, "R4 inverted level", int'(level_o[1]), 0);
    wr(32'h0000_0000);
    cyc(4);
    check(level_o[1] == 1'b1, "R4 non-inverted", int'(level_o[1]), 1);

    // R6/R7 filter rate 0 count 3: 2-cycle glitch rejected, long low accepted
    wr(32'h0000_3131);
    cyc(4);
    pin_i = 2'b00; cyc(2); pin_i = 2'b11; cyc(6);
    check(level_o == 2'b11, "R7 glitch rejected", int'(level_o), 3);
    pin_i = 2'b00; cyc(5);
    check(level_o == 2'b11, "R6 not yet qualified", int'(level_o), 3);
    cyc(2);
    check(level_o == 2'b00, "R6 qualified low", int'(level_o), 0);
    pin_i = 2'b11; cyc(8);

    // R5 divided sampling exercised with model on every clock
    for (int r = 0; r < 8; r++) begin
      wr({16'h0, 8'h11 | 8'(r << 1), 8'h01 | 8'(r << 1)});
      for (int i = 0; i < 400; i++) begin
        if ($urandom_range(0, 9) == 0) pin_i = 2'($urandom);
        cyc(1);
      end
    end

    // mixed random configurations and pins
    for (int k = 0; k < 60; k++) begin
      wr($urandom);
      for (int i = 0; i < 300; i++) begin
        if ($urandom_range(0, 5) == 0) pin_i = 2'($urandom);
        cyc(1);
      end
    end

    done = 1;
    summary();
  end
endmodule